// File: doc/BRIEF.md
# Codec Serial Audio Frame Port

This block is the codec end of a synchronous serial audio link. From the system clock it makes a bit clock that runs 64 bit periods per sample frame. It marks the start of each frame with a one-slot sync pulse. Over the data line it sends one captured left and right sample, followed by a tail of status flags. On the return line it collects one playback left and right sample. The attached processor port runs in slave mode: it takes clock and sync from this block, captures on the falling clock edge and launches on the rising edge.

A two-bit format input picks one of three modes:
- **Full frame:** all 64 slots are clocked, and the status tail is sent.
- **Short frame:** only the 32 audio bits are sent. The bit clock and the data line then stay low for the rest of the frame period.
- **Mono:** the same sample is carried in both channel elements.

The format, the capture samples and the status flags are latched only at a frame boundary, so mid-frame changes do not tear a frame. The received words appear on parallel outputs with a one-cycle strobe once the last right-channel bit has been captured.

Top module: `audio_frame_port`

## Requirements
- R1: The bit clock `sclk` has a period of 2*HALF_DIV system cycles and is high for the first HALF_DIV cycles of each bit slot. A frame has 64 slots, numbered 0 to 63.
- R2: Under reset `sclk`, `fsync`, `sdout` and `pb_valid` are low. The first `fsync` is seen 64*2*HALF_DIV cycles after reset is released. The partial frame before it carries no audio.
- R3: `fsync` is high for exactly slot 0 of each frame, and frames repeat every 64 slots. Data bit 0 of the frame is in slot 1, one bit period after the sync.
- R4: `sdout` changes only together with a rising edge of `sclk`. `sdin` is sampled at the falling edge of `sclk` in slots 1 to 32.
- R5: Frame bits 0 to 15 are the left sample, MSB first, and bits 16 to 31 are the right sample, MSB first. Bits 32 to 32+STAT_W-1 are `stat_flags`, MSB first. All later bits, and `sdout` in slot 0, are zero.
- R6: With `fmt_sel`=01 (short frame), `sclk` pulses only in slots 0 to 32. Both `sclk` and `sdout` stay low in slots 33 to 63.
- R7: With `fmt_sel`=10 (mono), the right element sent equals the left capture sample. `pb_right` equals `pb_left`, which is the received left element.
- R8: `fmt_sel`=00 and `fmt_sel`=11 both select the full 64-slot frame with stereo data and the status tail.
- R9: `fmt_sel`, `cap_left`, `cap_right` and `stat_flags` are sampled only at the start of slot 0. Changing them inside a frame has no effect on that frame.
- R10: `pb_valid` is high for exactly one cycle per frame, in the cycle after the falling `sclk` edge of slot 32. At the same time `pb_left` and `pb_right` carry the two received elements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_sel | input | 2 | Frame format: 00/11 full, 01 short, 10 mono |
| cap_left | input | 16 | Left capture sample to send |
| cap_right | input | 16 | Right capture sample to send |
| stat_flags | input | STAT_W | Status flags placed in the frame tail |
| sclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync pulse (slot 0) |
| sdout | output | 1 | Serial capture data out |
| sdin | input | 1 | Serial playback data in |
| pb_left | output | 16 | Received left playback element |
| pb_right | output | 16 | Received right playback element |
| pb_valid | output | 1 | One-cycle strobe for the playback words |

## Verification
The bench acts as the far end of the link. It sweeps all four format codes over a dozen frames. Each frame uses its own sample values: a walking one merged with a walking bit from the top, the complemented and rotated right sample, and all-ones and all-zero frames. These separate lost or swapped channels, bit-order and off-by-one slot errors, and a mono path that fails to duplicate.

Short-frame sweeps count the bit clock pulses and watch the quiet tail. Two frames change every latched input at slot 10, which shows whether the frame-boundary latch is honoured. The received words are checked against the values the bench drove on the falling-edge sampling point.

// File: rtl/afp_pkg.sv
package afp_pkg;
    localparam int ELEM_W     = 16;
    localparam int FRAME_BITS = 64;
    localparam int AUDIO_BITS = 2 * ELEM_W;
    localparam int SLOT_W     = $clog2(FRAME_BITS);

    typedef enum logic [1:0] {
        FMT_FULL  = 2'b00,
        FMT_SHORT = 2'b01,
        FMT_MONO  = 2'b10,
        FMT_FULL2 = 2'b11
    } fmt_e;

    typedef struct packed {
        logic [ELEM_W-1:0] left;
        logic [ELEM_W-1:0] right;
    } stereo_t;

    function automatic logic fmt_is_mono(fmt_e f);
        return f == FMT_MONO;
    endfunction

    function automatic logic fmt_is_short(fmt_e f);
        return f == FMT_SHORT;
    endfunction
endpackage

// File: rtl/afp_slot_timer.sv
module afp_slot_timer
    import afp_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              halt,
    output logic              rise_ev,
    output logic              fall_ev,
    output logic              frame_start,
    output logic              run_nxt,
    output logic [SLOT_W-1:0] slot,
    output logic              sclk,
    output logic              fsync
);
    localparam int PER  = 2 * HALF_DIV;
    localparam int PH_W = (PER > 2) ? $clog2(PER) : 1;

    logic [PH_W-1:0]   ph;
    logic [SLOT_W-1:0] nxt_slot;

    assign rise_ev     = (ph == PH_W'(PER - 1));
    assign fall_ev     = (ph == PH_W'(HALF_DIV - 1));
    assign frame_start = rise_ev && (slot == SLOT_W'(FRAME_BITS - 1));
    assign nxt_slot    = slot + SLOT_W'(1);
    assign run_nxt     = !halt || (nxt_slot <= SLOT_W'(AUDIO_BITS));

    always_ff @(posedge clk) begin
        if (rst) begin
            ph    <= '0;
            slot  <= '0;
            sclk  <= 1'b0;
            fsync <= 1'b0;
        end else begin
            ph <= rise_ev ? '0 : ph + PH_W'(1);
            if (rise_ev) begin
                slot  <= nxt_slot;
                sclk  <= run_nxt;
                fsync <= frame_start;
            end else if (fall_ev) begin
                sclk <= 1'b0;
            end
        end
    end

    // R3: sync only in slot 0
    p_fsync_slot0_r3: assert property (@(posedge clk) disable iff (rst)
        fsync |-> (slot == '0));

    // R1: clock high only in the first half of a slot
    p_sclk_half_r1: assert property (@(posedge clk) disable iff (rst)
        sclk |-> (ph < PH_W'(HALF_DIV)));

    // R1: slot advances only on a bit boundary
    p_slot_step_r1: assert property (@(posedge clk) disable iff (rst)
        !rise_ev |=> $stable(slot));
endmodule

// File: rtl/afp_tx_shifter.sv
module afp_tx_shifter
    import afp_pkg::*;
#(
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              rise_ev,
    input  logic              run_nxt,
    input  logic              mono_new,
    input  stereo_t           cap,
    input  logic [STAT_W-1:0] stat,
    output logic              sdout
);
    localparam int PAD_W = FRAME_BITS - AUDIO_BITS - STAT_W;

    logic [FRAME_BITS-1:0] word;
    logic [FRAME_BITS-1:0] sh;

    always_comb begin
        word = {cap.left, (mono_new ? cap.left : cap.right), stat, PAD_W'(0)};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh    <= '0;
            sdout <= 1'b0;
        end else if (frame_start) begin
            sh    <= word;
            sdout <= 1'b0;
        end else if (rise_ev) begin
            sh    <= {sh[FRAME_BITS-2:0], 1'b0};
            sdout <= run_nxt & sh[FRAME_BITS-1];
        end
    end

    // R4: data moves only with a bit-clock rising event
    p_sdout_on_rise_r4: assert property (@(posedge clk) disable iff (rst)
        (!rise_ev && !frame_start) |=> $stable(sdout));
endmodule

// File: rtl/afp_rx_deser.sv
module afp_rx_deser
    import afp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fall_ev,
    input  logic [SLOT_W-1:0] slot,
    input  logic              framed,
    input  logic              mono,
    input  logic              sdin,
    output stereo_t           pb,
    output logic              pb_valid
);
    logic [AUDIO_BITS-1:0] acc;
    logic [AUDIO_BITS-1:0] word;
    logic                  in_data;
    logic                  last_bit;

    assign word     = {acc[AUDIO_BITS-2:0], sdin};
    assign in_data  = (slot != '0) && (slot <= SLOT_W'(AUDIO_BITS));
    assign last_bit = fall_ev && (slot == SLOT_W'(AUDIO_BITS));

    always_ff @(posedge clk) begin
        if (rst) begin
            acc      <= '0;
            pb       <= '0;
            pb_valid <= 1'b0;
        end else begin
            pb_valid <= 1'b0;
            if (fall_ev && in_data) acc <= word;
            if (last_bit && framed) begin
                pb.left  <= word[AUDIO_BITS-1:ELEM_W];
                pb.right <= mono ? word[AUDIO_BITS-1:ELEM_W] : word[ELEM_W-1:0];
                pb_valid <= 1'b1;
            end
        end
    end

    // R7: mono playback words agree
    p_mono_pair_r7: assert property (@(posedge clk) disable iff (rst)
        (pb_valid && mono) |-> (pb.left == pb.right));
endmodule

// File: rtl/audio_frame_port.sv
module audio_frame_port
    import afp_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int STAT_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        fmt_sel,
    input  logic [ELEM_W-1:0] cap_left,
    input  logic [ELEM_W-1:0] cap_right,
    input  logic [STAT_W-1:0] stat_flags,
    output logic              sclk,
    output logic              fsync,
    output logic              sdout,
    input  logic              sdin,
    output logic [ELEM_W-1:0] pb_left,
    output logic [ELEM_W-1:0] pb_right,
    output logic              pb_valid
);
    fmt_e              cur_fmt;
    logic              framed;
    logic              rise_ev;
    logic              fall_ev;
    logic              frame_start;
    logic              run_nxt;
    logic [SLOT_W-1:0] slot;
    stereo_t           cap;
    stereo_t           pb;

    assign cap.left  = cap_left;
    assign cap.right = cap_right;
    assign pb_left   = pb.left;
    assign pb_right  = pb.right;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_fmt <= FMT_FULL;
            framed  <= 1'b0;
        end else if (frame_start) begin
            cur_fmt <= fmt_e'(fmt_sel);
            framed  <= 1'b1;
        end
    end

    afp_slot_timer #(.HALF_DIV(HALF_DIV)) timer_i (
        .clk         (clk),
        .rst         (rst),
        .halt        (fmt_is_short(cur_fmt)),
        .rise_ev     (rise_ev),
        .fall_ev     (fall_ev),
        .frame_start (frame_start),
        .run_nxt     (run_nxt),
        .slot        (slot),
        .sclk        (sclk),
        .fsync       (fsync)
    );

    afp_tx_shifter #(.STAT_W(STAT_W)) tx_i (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .rise_ev     (rise_ev),
        .run_nxt     (run_nxt),
        .mono_new    (fmt_is_mono(fmt_e'(fmt_sel))),
        .cap         (cap),
        .stat        (stat_flags),
        .sdout       (sdout)
    );

    afp_rx_deser rx_i (
        .clk      (clk),
        .rst      (rst),
        .fall_ev  (fall_ev),
        .slot     (slot),
        .framed   (framed),
        .mono     (fmt_is_mono(cur_fmt)),
        .sdin     (sdin),
        .pb       (pb),
        .pb_valid (pb_valid)
    );

    // R9: format changes only at a frame start
    p_fmt_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(cur_fmt));

    // R6: short frame keeps clock and data low in the tail
    p_short_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (fmt_is_short(cur_fmt) && (slot > SLOT_W'(AUDIO_BITS))) |-> (!sclk && !sdout));

    // R5: data line low during the sync slot
    p_sync_slot_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        fsync |-> !sdout);

    // R10: strobe lasts one cycle and sits in slot 32
    p_valid_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        pb_valid |=> !pb_valid);
    p_valid_slot_r10: assert property (@(posedge clk) disable iff (rst)
        pb_valid |-> (slot == SLOT_W'(AUDIO_BITS)));
endmodule

// File: tb/audio_frame_port_tb_top.sv
module audio_frame_port_tb_top;
    localparam int HALF   = 2;
    localparam int PER    = 2 * HALF;
    localparam int FRAME  = 64 * PER;
    localparam int STW    = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  fmt_sel = 2'b00;
    logic [15:0] cap_left = '0;
    logic [15:0] cap_right = '0;
    logic [STW-1:0] stat_flags = '0;
    logic        sdin = 1'b0;
    logic        sclk, fsync, sdout, pb_valid;
    logic [15:0] pb_left, pb_right;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // expected state for the frame being latched
    logic [1:0]  e_fmt;
    logic [15:0] e_l, e_r, e_rl, e_rr;
    logic [STW-1:0] e_st;

    always #10 clk = ~clk;

    audio_frame_port #(.HALF_DIV(HALF), .STAT_W(STW)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .fmt_sel    (fmt_sel),
        .cap_left   (cap_left),
        .cap_right  (cap_right),
        .stat_flags (stat_flags),
        .sclk       (sclk),
        .fsync      (fsync),
        .sdout      (sdout),
        .sdin       (sdin),
        .pb_left    (pb_left),
        .pb_right   (pb_right),
        .pb_valid   (pb_valid)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic setup_frame(input logic [1:0] f, input logic [15:0] l, r,
                               input logic [STW-1:0] st, input logic [15:0] rl, rr);
        fmt_sel = f; cap_left = l; cap_right = r; stat_flags = st;
        e_fmt = f; e_l = l; e_r = r; e_st = st; e_rl = rl; e_rr = rr;
    endtask

    // called at a negedge just before the frame's sync becomes visible
    task automatic take_frame(input bit first, input bit glitch);
        logic [63:0] exp_tx;
        logic [31:0] rxw;
        bit mono, shrt;
        int rises = 0, tx_bad = 0, fs_bad = 0, quiet_bad = 0;
        int vcount = 0, vn = -1;
        logic [15:0] got_l = '0, got_r = '0;
        logic prev;
        mono = (e_fmt == 2'b10);
        shrt = (e_fmt == 2'b01);
        exp_tx = {e_l, (mono ? e_l : e_r), e_st, 24'h0};
        rxw = {e_rl, e_rr};
        if (first) begin
            int n = 0;
            int early_valid = 0;
            while (!fsync && n < 2 * FRAME) begin
                @(negedge clk);
                n++;
                if (pb_valid) early_valid++;
            end
            // R2: first sync one full frame after reset release
            chk(n == FRAME, "R2", "first fsync delay", 64'(n), 64'(FRAME));
            // R10: no playback strobe in the partial frame
            chk(early_valid == 0, "R10", "strobe before first sync", 64'(early_valid), 64'd0);
        end else begin
            @(negedge clk);
            // R3: frames repeat every 64 slots
            chk(fsync == 1'b1, "R3", "fsync period", 64'(fsync), 64'd1);
        end
        prev = sclk;
        for (int n = 1; n < FRAME; n++) begin
            @(negedge clk);
            if (sclk && !prev) begin
                rises++;
                if (sdout !== exp_tx[64 - rises]) tx_bad++;
                sdin = (rises <= 32) ? rxw[32 - rises] : 1'b0;
            end
            if (fsync != (n < PER)) fs_bad++;
            if (shrt && n >= 33 * PER && (sclk || sdout)) quiet_bad++;
            if (pb_valid) begin
                vcount++;
                vn = n;
                got_l = pb_left;
                got_r = pb_right;
            end
            if (glitch && n == 10 * PER) begin
                fmt_sel = ~e_fmt; cap_left = ~e_l; cap_right = ~e_r; stat_flags = ~e_st;
            end
            prev = sclk;
        end
        chk(rises == (shrt ? 32 : 63), shrt ? "R6" : "R1", "sclk pulses after sync",
            64'(rises), 64'(shrt ? 32 : 63));
        chk(tx_bad == 0, mono ? "R7" : (e_fmt == 2'b11 ? "R8" : "R5"),
            "serial bits wrong (count)", 64'(tx_bad), 64'd0);
        chk(fs_bad == 0, "R3", "fsync width in cycles wrong (count)", 64'(fs_bad), 64'd0);
        if (shrt) chk(quiet_bad == 0, "R6", "short tail not quiet", 64'(quiet_bad), 64'd0);
        chk(vcount == 1 && vn == 32 * PER + HALF, "R10", "strobe position",
            64'(vn), 64'(32 * PER + HALF));
        // R4: words assembled from falling-edge samples
        chk(got_l == e_rl, "R4", "pb_left", 64'(got_l), 64'(e_rl));
        chk(got_r == (mono ? e_rl : e_rr), mono ? "R7" : "R4", "pb_right",
            64'(got_r), 64'(mono ? e_rl : e_rr));
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog expired: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2: reset state
        chk(!sclk && !fsync && !sdout && !pb_valid, "R2", "reset outputs",
            64'({sclk, fsync, sdout, pb_valid}), 64'd0);
        setup_frame(2'b00, 16'h8001, 16'h1234, 8'hA5, 16'hBEEF, 16'h0F1E);
        rst = 1'b0;
        take_frame(1'b1, 1'b0);
        for (int i = 0; i < 12; i++) begin
            logic [15:0] l, r, rl;
            l  = 16'((32'h1 << i) | (32'h8000 >> i));
            r  = ~{l[11:0], l[15:12]} ^ 16'(i * 16'h1111);
            rl = 16'(i * 16'h0F0F) ^ 16'hC3A5;
            setup_frame(2'(i % 4), l, r, 8'(8'h81 ^ (i * 37)), rl, ~{rl[7:0], rl[15:8]});
            take_frame(1'b0, 1'b0);
        end
        setup_frame(2'b00, 16'hFFFF, 16'hFFFF, 8'hFF, 16'hFFFF, 16'hFFFF);
        take_frame(1'b0, 1'b0);
        setup_frame(2'b10, 16'h0000, 16'hFFFF, 8'h00, 16'h0000, 16'hFFFF);
        take_frame(1'b0, 1'b0);
        // R9: mid-frame input changes ignored
        setup_frame(2'b00, 16'h3C5A, 16'hC3A5, 8'h96, 16'h1357, 16'h2468);
        take_frame(1'b0, 1'b1);
        setup_frame(2'b01, 16'h7E81, 16'h1818, 8'h3C, 16'hACE1, 16'h5EED);
        take_frame(1'b0, 1'b1);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule